// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt lines into a pending-request vector. Each line is sampled on every clock. A per-line trigger-mode bit decides how the line is read. A level-sensitive line simply mirrors its input into its request bit. An edge-sensitive line records a request on a low-to-high transition and keeps that request until it is acknowledged. A stored copy of each line's previous level is what makes the transition detection possible.

A priority resolver downstream reads the pending vector. When the resolver services a line, it pulses an acknowledge with the line index. For every rising input, the block reports one of three outcomes: the line is masked, a new request was taken, or the request merged into one that was already pending.

A reinitialization strobe clears the stored levels. It keeps pending level requests and discards pending edge requests, and it reports which edge requests were lost. The trigger-mode register has a write mask that depends on the instance role, so some lines are fixed as edge-sensitive. No data stream crosses the block's edge, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `elirq_latch`

## Requirements
- R1: A synchronous reset clears the pending vector, the stored levels, the trigger-mode register and every event output to zero.
- R2: On a line whose trigger-mode bit is 1 (level sensitive), the pending bit equals the input sampled at the previous clock edge: set when the input is high, cleared when it is low.
- R3: On a line whose trigger-mode bit is 0 (edge sensitive), a high input sets the pending bit only if the stored previous level was low. Holding the input high does not produce a second request.
- R4: On an edge-sensitive line, a low input updates only the stored level. A pending bit that is already set stays set.
- R5: On a rising input (stored level low, input high), exactly one event bit for that line pulses for one cycle, one edge after sampling. The bit is ev_masked_o if the mask input bit is 1, otherwise ev_coal_o if the pending bit was already 1, otherwise ev_new_o. A masked line still latches its request.
- R6: An acknowledge (ack_valid_i with ack_idx_i naming the line) clears the pending bit of an edge-sensitive line and leaves a level-sensitive line untouched. A rising edge on the same line in the same cycle wins, and the bit stays set.
- R7: A trigger-mode write stores the write data ANDed with a fixed mask: 0xF8 when IS_PRIMARY=1, and 0xDE otherwise. Bits outside the mask always read 0, so those lines stay edge sensitive.
- R8: A reinit pulse clears all stored levels and keeps only the pending bits of level-sensitive lines. In the next cycle, dropped_o shows the edge-sensitive pending bits that were discarded. Sampling and acknowledge are ignored in the reinit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 8 | Raw interrupt lines |
| imr_i | input | 8 | Per-line mask, used only to classify events |
| ack_valid_i | input | 1 | One-cycle acknowledge strobe |
| ack_idx_i | input | 3 | Index of the acknowledged line |
| reinit_i | input | 1 | Reinitialization strobe |
| trig_we_i | input | 1 | Trigger-mode write enable |
| trig_wdata_i | input | 8 | Trigger-mode write data, 1 = level |
| irr_o | output | 8 | Pending request vector |
| trig_mode_o | output | 8 | Current trigger-mode register |
| ev_new_o | output | 8 | Pulse: new request latched |
| ev_coal_o | output | 8 | Pulse: rising edge merged into a pending request |
| ev_masked_o | output | 8 | Pulse: rising edge on a masked line |
| dropped_o | output | 8 | Pulse: edge requests discarded by reinit |

## Verification
The bench holds an edge line high across several cycles. A design that treated level as edge would raise a second new-request pulse, or would lose the request when the line falls. It fires an acknowledge into a level line, where a wrong design would drop a request whose input is still asserted. It also fires an acknowledge in the same cycle as a fresh edge, where a wrong design would lose that edge.

After reinit, the bench checks that the edge bits are reported and cleared while the level bits survive. Because the stored levels were cleared, the next cycle must show a still-high level line as coalesced and a still-high edge line as new. A design that kept the stored levels would show no event for either line. Writing all ones to both instance roles exposes a write mask that is missing or swapped.

// File: rtl/elirq_pkg.sv
package elirq_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);
  typedef logic [LINES-1:0] lvec_t;

  function automatic lvec_t wmask_for(input bit primary);
    return primary ? lvec_t'(8'hF8) : lvec_t'(8'hDE);
  endfunction
endpackage

// File: rtl/elirq_line_slice.sv
module elirq_line_slice (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic level_i,
  input  logic mask_i,
  input  logic ack_i,
  input  logic reinit_i,
  output logic irr_o,
  output logic ev_new_o,
  output logic ev_coal_o,
  output logic ev_mask_o,
  output logic drop_o
);
  logic last_q;
  logic rise;

  assign rise = line_i & ~last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q    <= 1'b0;
      irr_o     <= 1'b0;
      ev_new_o  <= 1'b0;
      ev_coal_o <= 1'b0;
      ev_mask_o <= 1'b0;
      drop_o    <= 1'b0;
    end else begin
      ev_new_o  <= 1'b0;
      ev_coal_o <= 1'b0;
      ev_mask_o <= 1'b0;
      drop_o    <= 1'b0;
      if (reinit_i) begin
        last_q <= 1'b0;
        irr_o  <= irr_o & level_i;
        drop_o <= irr_o & ~level_i;
      end else begin
        last_q <= line_i;
        if (level_i)   irr_o <= line_i;
        else if (rise) irr_o <= 1'b1;
        else if (ack_i) irr_o <= 1'b0;
        if (rise) begin
          if (mask_i)     ev_mask_o <= 1'b1;
          else if (irr_o) ev_coal_o <= 1'b1;
          else            ev_new_o  <= 1'b1;
        end
      end
    end
  end

  p_level_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (level_i && !reinit_i) |=> (irr_o == $past(line_i)));
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!level_i && !reinit_i && !ack_i && irr_o) |=> irr_o);
  p_one_event_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_new_o, ev_coal_o, ev_mask_o}));
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !level_i && !reinit_i && !rise) |=> !irr_o);
  p_reinit_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (reinit_i && level_i) |=> (irr_o == $past(irr_o)));
endmodule

// File: rtl/elirq_trig_reg.sv
module elirq_trig_reg
  import elirq_pkg::*;
#(
  parameter lvec_t WMASK = lvec_t'(8'hF8)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we_i,
  input  lvec_t wdata_i,
  output lvec_t mode_o
);
  always_ff @(posedge clk) begin
    if (rst)       mode_o <= '0;
    else if (we_i) mode_o <= wdata_i & WMASK;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mode_o));
  p_write_r7: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mode_o == ($past(wdata_i) & WMASK)));
endmodule

// File: rtl/elirq_latch.sv
module elirq_latch
  import elirq_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_i,
  input  logic [LINES-1:0] imr_i,
  input  logic             ack_valid_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  input  logic             reinit_i,
  input  logic             trig_we_i,
  input  logic [LINES-1:0] trig_wdata_i,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] trig_mode_o,
  output logic [LINES-1:0] ev_new_o,
  output logic [LINES-1:0] ev_coal_o,
  output logic [LINES-1:0] ev_masked_o,
  output logic [LINES-1:0] dropped_o
);
  localparam lvec_t WMASK = wmask_for(IS_PRIMARY);

  lvec_t ack_hit;

  always_comb begin
    ack_hit = '0;
    if (ack_valid_i) ack_hit[ack_idx_i] = 1'b1;
  end

  elirq_trig_reg #(.WMASK(WMASK)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .we_i    (trig_we_i),
    .wdata_i (trig_wdata_i),
    .mode_o  (trig_mode_o)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    elirq_line_slice u_slice (
      .clk       (clk),
      .rst       (rst),
      .line_i    (line_i[g]),
      .level_i   (trig_mode_o[g]),
      .mask_i    (imr_i[g]),
      .ack_i     (ack_hit[g]),
      .reinit_i  (reinit_i),
      .irr_o     (irr_o[g]),
      .ev_new_o  (ev_new_o[g]),
      .ev_coal_o (ev_coal_o[g]),
      .ev_mask_o (ev_masked_o[g]),
      .drop_o    (dropped_o[g])
    );
  end

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (irr_o == '0 && trig_mode_o == '0 && dropped_o == '0));
  p_no_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !reinit_i |=> (dropped_o == '0));
endmodule

// File: tb/elirq_latch_tb.sv
module elirq_latch_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] line_i, imr_i, trig_wdata_i;
  logic       ack_valid_i, reinit_i, trig_we_i;
  logic [2:0] ack_idx_i;
  logic [7:0] irr_o, trig_mode_o, ev_new_o, ev_coal_o, ev_masked_o, dropped_o;
  logic [7:0] irr_s, trig_s, n_s, c_s, m_s, d_s;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  elirq_latch #(.IS_PRIMARY(1'b1)) u_dut (
    .clk(clk), .rst(rst), .line_i(line_i), .imr_i(imr_i),
    .ack_valid_i(ack_valid_i), .ack_idx_i(ack_idx_i), .reinit_i(reinit_i),
    .trig_we_i(trig_we_i), .trig_wdata_i(trig_wdata_i),
    .irr_o(irr_o), .trig_mode_o(trig_mode_o), .ev_new_o(ev_new_o),
    .ev_coal_o(ev_coal_o), .ev_masked_o(ev_masked_o), .dropped_o(dropped_o));

  elirq_latch #(.IS_PRIMARY(1'b0)) u_dut_sec (
    .clk(clk), .rst(rst), .line_i(line_i), .imr_i(imr_i),
    .ack_valid_i(ack_valid_i), .ack_idx_i(ack_idx_i), .reinit_i(reinit_i),
    .trig_we_i(trig_we_i), .trig_wdata_i(trig_wdata_i),
    .irr_o(irr_s), .trig_mode_o(trig_s), .ev_new_o(n_s),
    .ev_coal_o(c_s), .ev_masked_o(m_s), .dropped_o(d_s));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; line_i = '0; imr_i = '0; ack_valid_i = 1'b0; ack_idx_i = '0;
    reinit_i = 1'b0; trig_we_i = 1'b0; trig_wdata_i = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic write_trig(input logic [7:0] v);
    trig_we_i = 1'b1; trig_wdata_i = v;
    step();
    trig_we_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irr", irr_o, 8'h00);
    check("R1 trig", trig_mode_o, 8'h00);
    check("R1 events", ev_new_o | ev_coal_o | ev_masked_o | dropped_o, 8'h00);
  endtask

  task automatic t_trig();
    do_reset();
    write_trig(8'hFF);
    check("R7 primary mask", trig_mode_o, 8'hF8);
    check("R7 secondary mask", trig_s, 8'hDE);
    write_trig(8'h07);
    check("R7 locked bits", trig_mode_o, 8'h00);
  endtask

  task automatic t_edge();
    do_reset();
    line_i = 8'h01; step();
    check("R3 edge latch", irr_o, 8'h01);
    check("R5 new event", ev_new_o, 8'h01);
    step();
    check("R3 held high irr", irr_o, 8'h01);
    check("R3 held high no event", ev_new_o | ev_coal_o, 8'h00);
    line_i = 8'h00; step();
    check("R4 low keeps pending", irr_o, 8'h01);
    line_i = 8'h01; step();
    check("R5 coalesced", ev_coal_o, 8'h01);
    check("R5 not new", ev_new_o, 8'h00);
    imr_i = 8'h02; line_i = 8'h03; step();
    check("R5 masked event", ev_masked_o, 8'h02);
    check("R5 masked others", ev_new_o | ev_coal_o, 8'h00);
    check("R5 masked still latches", irr_o, 8'h03);
  endtask

  task automatic t_level();
    do_reset();
    write_trig(8'h10);
    line_i = 8'h10; step();
    check("R2 level high", irr_o, 8'h10);
    check("R5 level new", ev_new_o, 8'h10);
    line_i = 8'h00; step();
    check("R2 level low", irr_o, 8'h00);
  endtask

  task automatic t_ack();
    do_reset();
    write_trig(8'h10);
    line_i = 8'h11; step();
    check("R6 setup", irr_o, 8'h11);
    line_i = 8'h10;
    ack_valid_i = 1'b1; ack_idx_i = 3'd4; step();
    ack_valid_i = 1'b0;
    check("R6 level ack ignored", irr_o, 8'h11);
    ack_valid_i = 1'b1; ack_idx_i = 3'd0; step();
    ack_valid_i = 1'b0;
    check("R6 edge ack clears", irr_o, 8'h10);
    line_i = 8'h11; ack_valid_i = 1'b1; ack_idx_i = 3'd0; step();
    ack_valid_i = 1'b0;
    check("R6 edge beats ack", irr_o, 8'h11);
    check("R6 edge beats ack event", ev_new_o, 8'h01);
  endtask

  task automatic t_reinit();
    do_reset();
    write_trig(8'h10);
    line_i = 8'h13; step();
    check("R8 setup", irr_o, 8'h13);
    line_i = 8'h11; reinit_i = 1'b1; step();
    reinit_i = 1'b0;
    check("R8 keeps level only", irr_o, 8'h10);
    check("R8 dropped report", dropped_o, 8'h03);
    check("R8 no sampling", ev_new_o | ev_coal_o, 8'h00);
    step();
    check("R8 last cleared new", ev_new_o, 8'h01);
    check("R8 last cleared coal", ev_coal_o, 8'h10);
    check("R8 irr after", irr_o, 8'h11);
    check("R8 dropped one cycle", dropped_o, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_trig();
    t_edge();
    t_level();
    t_ack();
    t_reinit();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule